// File: doc/BRIEF.md
# Coded Alive-Message Watchdog

This block is an independent hardware monitor that sits beside a processor running arithmetic-coded software. At intervals, the monitored side sends an alive message with two parts. The first is an error-accumulator word, which is the coded running sum of every instruction result and program-counter update. The second is the count of instructions executed so far.

For each message, the monitor takes the accumulator's residue modulo a fixed odd constant and compares it with the expected signature. It also confirms that the instruction count has moved forward since the last accepted message. A message that passes both tests restarts the timeout. A failed test, or a timeout with no passing message, raises a sticky fail-stop output and records the cause.

Messages arrive over a valid/ready handshake. While a residue computation is running, ready is held low. By default the residue is computed one accumulator bit per clock. A parameter selects a single-cycle divider instead.

Top module: `alive_guard`

## Requirements
- R1: After reset, `fail_stop` is 0, `fail_cause` is 3'b000 and `msg_ready` is 1.
- R2: A message is taken on a clock edge where `msg_valid` and `msg_ready` are both high. `msg_ready` then stays low for exactly ACC_W+1 clock cycles with the serial residue unit (1 cycle with the single-cycle unit). After that it returns high if the message passed.
- R3: When `msg_accum` modulo CODE_A differs from `expected_sig` (sampled as the check completes), the block fails with `fail_cause` bit 1 (bad code) set.
- R4: When `msg_version` is not strictly greater than the last accepted version, the block fails with `fail_cause` bit 2 (no progress) set. The last accepted version is 0 after reset, so a version equal to the previous one also fails.
- R5: If `timeout_cycles` clock edges pass without a passing message since reset or since the last pass, the block fails with `fail_cause` bit 0 (timeout) set. A passing message restarts this count on the edge where its verdict is made.
- R6: A message that fails both checks sets bits 1 and 2 of `fail_cause` together.
- R7: Once `fail_stop` is high, it and `fail_cause` hold until reset. `msg_ready` stays low, and any message presented afterwards has no effect.
- R8: Asserting `rst_n` low clears a latched failure and its cause, and brings `msg_ready` back high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| timeout_cycles | input | CNT_W | Clock edges allowed between passing messages |
| expected_sig | input | RES_W | Signature the accumulator residue must equal |
| msg_valid | input | 1 | Alive message present |
| msg_ready | output | 1 | Monitor can take a message |
| msg_accum | input | ACC_W | Coded error-accumulator word |
| msg_version | input | VER_W | Instruction count of the sender |
| fail_stop | output | 1 | Sticky fail-stop request |
| fail_cause | output | 3 | Bit 0 timeout, bit 1 bad code, bit 2 no progress |

## Verification
A wrong residue register shows up at the ports as a bad-code failure on a valid word, or as a missed failure on a corrupted word. Either one appears ACC_W+1 cycles after the handshake. A stuck or badly reloaded timer shows up as a timeout that arrives at the wrong edge. The timeout edge is checked to the exact cycle, both from reset and after a reload.

A lost last-version register either rejects an advancing count or accepts a repeated count. A wrong busy flag shows as a ready-low window of the wrong length.

// File: rtl/alive_pkg.sv
package alive_pkg;
   localparam int CAUSE_W = 3;

   typedef struct packed {
      logic no_progress;
      logic bad_code;
      logic timeout;
   } cause_t;
endpackage

// File: rtl/alive_residue.sv
module alive_residue #(
   parameter int ACC_W  = 16,
   parameter int CODE_A = 251,
   parameter int RES_W  = 8,
   parameter bit SERIAL = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [ACC_W-1:0] operand,
   output logic             done,
   output logic [RES_W-1:0] rem
);
   localparam int CNT_W = $clog2(ACC_W + 1);

   generate
      if (SERIAL) begin : g_serial
         logic [ACC_W-1:0] sh_q;
         logic [RES_W-1:0] rem_q;
         logic [CNT_W-1:0] cnt_q;
         logic             run_q;
         logic             done_q;
         logic [RES_W:0]   trial;

         assign trial = {rem_q, sh_q[ACC_W-1]};

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               sh_q   <= '0;
               rem_q  <= '0;
               cnt_q  <= '0;
               run_q  <= 1'b0;
               done_q <= 1'b0;
            end else begin
               done_q <= 1'b0;
               if (start) begin
                  sh_q  <= operand;
                  rem_q <= '0;
                  cnt_q <= CNT_W'(ACC_W);
                  run_q <= 1'b1;
               end else if (run_q) begin
                  if (trial >= (RES_W+1)'(CODE_A))
                     rem_q <= RES_W'(trial - (RES_W+1)'(CODE_A));
                  else
                     rem_q <= trial[RES_W-1:0];
                  sh_q  <= sh_q << 1;
                  cnt_q <= cnt_q - 1'b1;
                  if (cnt_q == CNT_W'(1)) begin
                     run_q  <= 1'b0;
                     done_q <= 1'b1;
                  end
               end
            end
         end

         assign done = done_q;
         assign rem  = rem_q;

         // R2
         no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
            run_q |-> !start);
      end else begin : g_direct
         logic [RES_W-1:0] rem_q;
         logic             done_q;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               rem_q  <= '0;
               done_q <= 1'b0;
            end else begin
               done_q <= start;
               if (start)
                  rem_q <= RES_W'(32'(operand) % CODE_A);
            end
         end

         assign done = done_q;
         assign rem  = rem_q;
      end
   endgenerate

   // R3
   rem_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (32'(rem) < CODE_A));
endmodule

// File: rtl/alive_timer.sv
module alive_timer #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             freeze,
   input  logic             reload,
   input  logic [CNT_W-1:0] limit,
   output logic             expire
);
   logic [CNT_W-1:0] elapsed_q;
   logic [CNT_W:0]   nxt;

   assign nxt    = {1'b0, elapsed_q} + 1'b1;
   assign expire = !freeze && !reload && (nxt >= {1'b0, limit});

   always_ff @(posedge clk) begin
      if (!rst_n)
         elapsed_q <= '0;
      else if (freeze)
         elapsed_q <= elapsed_q;
      else if (reload)
         elapsed_q <= '0;
      else if (!expire)
         elapsed_q <= nxt[CNT_W-1:0];
   end

   // R5
   timeout_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      expire |=> freeze);
endmodule

// File: rtl/alive_guard.sv
module alive_guard #(
   parameter int ACC_W  = 16,
   parameter int VER_W  = 16,
   parameter int CNT_W  = 16,
   parameter int CODE_A = 251,
   parameter int RES_W  = $clog2(CODE_A),
   parameter bit SERIAL = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] timeout_cycles,
   input  logic [RES_W-1:0] expected_sig,
   input  logic             msg_valid,
   output logic             msg_ready,
   input  logic [ACC_W-1:0] msg_accum,
   input  logic [VER_W-1:0] msg_version,
   output logic             fail_stop,
   output logic [2:0]       fail_cause
);
   import alive_pkg::*;

   generate
      if (CODE_A < 3 || (CODE_A & (CODE_A - 1)) == 0) begin : g_bad_a
         $error("CODE_A must be at least 3 and not a power of two");
      end
      if (RES_W != $clog2(CODE_A)) begin : g_bad_w
         $error("RES_W must equal clog2(CODE_A)");
      end
      if (ACC_W <= RES_W) begin : g_bad_acc
         $error("ACC_W must exceed RES_W");
      end
   endgenerate

   logic             busy_q;
   logic             fail_q;
   cause_t           cause_q;
   logic [VER_W-1:0] prev_ver_q;
   logic [VER_W-1:0] ver_q;
   logic             accept;
   logic             done;
   logic [RES_W-1:0] rem;
   logic             code_ok;
   logic             prog_ok;
   logic             pass;
   logic             expire;
   cause_t           cause_d;

   assign msg_ready = !busy_q && !fail_q;
   assign accept    = msg_valid && msg_ready;
   assign code_ok   = (rem == expected_sig);
   assign prog_ok   = (ver_q > prev_ver_q);
   assign pass      = done && code_ok && prog_ok && !fail_q;

   always_comb begin
      cause_d.timeout     = expire;
      cause_d.bad_code    = done && !code_ok;
      cause_d.no_progress = done && !prog_ok;
   end

   alive_residue #(
      .ACC_W (ACC_W),
      .CODE_A(CODE_A),
      .RES_W (RES_W),
      .SERIAL(SERIAL)
   ) residue_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (accept),
      .operand(msg_accum),
      .done   (done),
      .rem    (rem)
   );

   alive_timer #(
      .CNT_W(CNT_W)
   ) timer_i (
      .clk   (clk),
      .rst_n (rst_n),
      .freeze(fail_q),
      .reload(pass),
      .limit (timeout_cycles),
      .expire(expire)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q     <= 1'b0;
         fail_q     <= 1'b0;
         cause_q    <= '0;
         prev_ver_q <= '0;
         ver_q      <= '0;
      end else begin
         if (accept) begin
            busy_q <= 1'b1;
            ver_q  <= msg_version;
         end
         if (done)
            busy_q <= 1'b0;
         if (pass)
            prev_ver_q <= ver_q;
         if (!fail_q && (|cause_d)) begin
            fail_q  <= 1'b1;
            cause_q <= cause_d;
         end
      end
   end

   assign fail_stop  = fail_q;
   assign fail_cause = cause_q;

   // R7
   fail_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fail_stop |=> fail_stop);

   // R7
   cause_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fail_stop |=> $stable(fail_cause));

   // R7
   fail_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fail_stop |-> (fail_cause != 3'b000));

   // R2
   handshake_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> !msg_ready);

   // R4
   prog_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pass |=> (prev_ver_q > $past(prev_ver_q)));
endmodule

// File: tb/alive_guard_tb_top.sv
`timescale 1ns/1ps
module alive_guard_tb_top;
   localparam int ACC_W  = 16;
   localparam int VER_W  = 16;
   localparam int CNT_W  = 16;
   localparam int CODE_A = 251;
   localparam int RES_W  = 8;
   localparam int LAT    = ACC_W + 1;
   localparam int NVEC   = 10;

   // fields: accum, version, signature, expected cause
   localparam logic [ACC_W+VER_W+RES_W+3-1:0] VEC [NVEC] = '{
      {16'd2517,  16'd1, 8'd7,   3'b000},
      {16'd50450, 16'd2, 8'd250, 3'b000},
      {16'd753,   16'd3, 8'd0,   3'b000},
      {16'd2516,  16'd4, 8'd7,   3'b010},
      {16'd2517,  16'd0, 8'd7,   3'b100},
      {16'd65535, 16'd5, 8'd24,  3'b000},
      {16'd65535, 16'd5, 8'd24,  3'b100},
      {16'd753,   16'd3, 8'd1,   3'b010},
      {16'd2517,  16'd9, 8'd7,   3'b000},
      {16'd2518,  16'd4, 8'd7,   3'b110}
   };

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [CNT_W-1:0] timeout_cycles = 16'd100;
   logic [RES_W-1:0] expected_sig = '0;
   logic             msg_valid = 1'b0;
   logic             msg_ready;
   logic [ACC_W-1:0] msg_accum = '0;
   logic [VER_W-1:0] msg_version = '0;
   logic             fail_stop;
   logic [2:0]       fail_cause;

   int checks = 0;
   int failures = 0;
   int low_cnt;
   bit done_flag = 1'b0;

   always #2.5 clk = ~clk;

   alive_guard dut_i (
      .clk           (clk),
      .rst_n         (rst_n),
      .timeout_cycles(timeout_cycles),
      .expected_sig  (expected_sig),
      .msg_valid     (msg_valid),
      .msg_ready     (msg_ready),
      .msg_accum     (msg_accum),
      .msg_version   (msg_version),
      .fail_stop     (fail_stop),
      .fail_cause    (fail_cause)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   // presents one message, returns at the negedge after the verdict edge
   task automatic send(input logic [ACC_W-1:0] acc, input logic [VER_W-1:0] ver,
                       input logic [RES_W-1:0] sig);
      @(negedge clk);
      msg_valid    = 1'b1;
      msg_accum    = acc;
      msg_version  = ver;
      expected_sig = sig;
      @(posedge clk);
      @(negedge clk);
      msg_valid = 1'b0;
      low_cnt = 0;
      for (int i = 0; i < LAT; i++) begin
         if (!msg_ready) low_cnt++;
         @(negedge clk);
      end
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!done_flag) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin : main
      do_reset();
      // R1 reset state
      chk(fail_stop == 1'b0, "R1", fail_stop, 0);
      chk(fail_cause == 3'b000, "R1", fail_cause, 0);
      chk(msg_ready == 1'b1, "R1", msg_ready, 1);

      // table walk: R2 R3 R4 R6
      for (int v = 0; v < NVEC; v++) begin
         logic [2:0] ec;
         string tag;
         ec = VEC[v][2:0];
         tag = (ec == 3'b000) ? "R2" : (ec == 3'b010) ? "R3" :
               (ec == 3'b100) ? "R4" : "R6";
         send(VEC[v][ACC_W+VER_W+RES_W+2 -: ACC_W],
              VEC[v][VER_W+RES_W+2 -: VER_W],
              VEC[v][RES_W+2 -: RES_W]);
         chk(fail_cause == ec, tag, fail_cause, ec);
         chk(fail_stop == (ec != 3'b000), tag, fail_stop, ec != 3'b000);
         if (ec == 3'b000) begin
            chk(low_cnt == LAT, "R2", low_cnt, LAT);
            chk(msg_ready == 1'b1, "R2", msg_ready, 1);
         end else begin
            do_reset();
         end
      end

      // R5 timeout from reset, exact edge
      timeout_cycles = 16'd20;
      do_reset();
      repeat (19) @(posedge clk);
      @(negedge clk);
      chk(fail_stop == 1'b0, "R5", fail_stop, 0);
      @(posedge clk);
      @(negedge clk);
      chk(fail_stop == 1'b1, "R5", fail_stop, 1);
      chk(fail_cause == 3'b001, "R5", fail_cause, 1);

      // R7 sticky: message after failure has no effect
      send(16'd2517, 16'd7, 8'd7);
      chk(fail_cause == 3'b001, "R7", fail_cause, 1);
      chk(fail_stop == 1'b1, "R7", fail_stop, 1);
      chk(msg_ready == 1'b0, "R7", msg_ready, 0);

      // R8 reset clears failure
      timeout_cycles = 16'd40;
      do_reset();
      chk(fail_stop == 1'b0, "R8", fail_stop, 0);
      chk(fail_cause == 3'b000, "R8", fail_cause, 0);
      chk(msg_ready == 1'b1, "R8", msg_ready, 1);

      // R5 reload by a pass: timeout 40 edges after verdict edge
      repeat (10) @(negedge clk);
      send(16'd2517, 16'd3, 8'd7);
      chk(fail_stop == 1'b0, "R5", fail_stop, 0);
      repeat (39) @(posedge clk);
      @(negedge clk);
      chk(fail_stop == 1'b0, "R5", fail_stop, 0);
      @(posedge clk);
      @(negedge clk);
      chk(fail_stop == 1'b1, "R5", fail_stop, 1);
      chk(fail_cause == 3'b001, "R5", fail_cause, 1);

      done_flag = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule